// File: doc/BRIEF.md
# Timer Slave-Mode Controller

This block decides how a general-purpose timer's 16-bit up-counter advances, using one selected trigger line. A 3-bit source field picks one of eight candidate trigger inputs. These are four internal timer links, an edge-detected raw channel-1 input, two filtered channel inputs and an external input. A 3-bit mode field then chooses what that line does to the counter. It can clear the counter on a rising edge, gate the counter while the line is high, start the counter on a rising edge, or clock the counter once per rising edge. When slave control is off, the counter runs on every clock cycle while it is enabled. The three encoder codes are decoded and behave the same as slave control off.

Software loads a small control register that holds the mode, the source and a master/slave sync bit. Software also writes the counter-enable bit and supplies the auto-reload limit. The block reports the count, the enable bit, a trigger-event strobe and a one-cycle overflow pulse. The asynchronous active-low reset is released through a two-stage synchroniser. All state therefore leaves reset on the third rising clock edge after `rst_n` goes high.

Top module: `tmr_slave_ctrl`

## Requirements
- R1: After reset, `count` is 0, `cnt_en` is 0, `ovf` is 0, `sync_en` is 0, and the control register holds 0 (slave control off, source 0).
- R2: The control word is laid out as mode in bits [2:0], source in bits [5:3] and sync in bit [6]. A write with `ctl_wr` takes effect from the next cycle. Source code k selects `trig_in[k]` for every k from 0 to 7.
- R3: Mode 000: on every clock edge where `cnt_en` is 1, the counter advances by one. Otherwise it holds its value.
- R4: Modes 001, 010 and 011 behave exactly like mode 000.
- R5: Mode 100: on a cycle where the selected trigger is 1 and was 0 on the previous cycle (a rising edge), `trig_evt` is 1 during that cycle and `count` becomes 0 at the next edge.
- R6: Mode 101: the counter advances only on edges where `cnt_en` is 1 and the selected trigger is 1.
- R7: Mode 110: a rising edge of the selected trigger sets `cnt_en` to 1 at the next edge, even if a software write of 0 occurs in the same cycle. Without a trigger edge, `cnt_en_wr` loads `cnt_en_val`.
- R8: Mode 111: with `cnt_en` at 1, the counter advances by one per rising edge of the selected trigger and holds at all other times.
- R9: An advance when `count` equals `arr` sets `count` to 0 and raises `ovf` for that one following cycle only.
- R10: In mode 100 a clearing edge overrides any advance in the same cycle and produces no `ovf`, even when `count` equals `arr`.
- R11: The sync bit is held in the control register and is visible on `sync_en`.
- R12: `trig_evt` is 1 only in modes 100 to 111, on a rising edge of the selected trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_din | input | 7 | Control word: sync[6], source[5:3], mode[2:0] |
| cnt_en_wr | input | 1 | Software write strobe for the counter-enable bit |
| cnt_en_val | input | 1 | Value written to the counter-enable bit |
| arr | input | 16 | Auto-reload limit |
| trig_in | input | 8 | Candidate trigger lines, indexed by source code |
| count | output | 16 | Counter value |
| cnt_en | output | 1 | Counter-enable bit |
| trig_evt | output | 1 | Trigger-event strobe |
| ovf | output | 1 | One-cycle wrap pulse |
| sync_en | output | 1 | Master/slave synchronisation enable |

## Verification
The hardest cases arise when two events coincide. One is a reset-mode edge that arrives exactly when the counter sits at the reload limit. The other is a trigger-mode edge that arrives in the same cycle as a software write that clears the enable. A directed pass steers the counter to the limit with a small `arr` and then raises the selected line. The bulk of the stimulus sweeps every mode against every source with pseudo-random trigger patterns and occasional enable writes. This sweep also produces spurious edges on unselected lines and edges caused by switching sources.

// File: rtl/tmr_slave_pkg.sv
package tmr_slave_pkg;

  localparam int SRC_W  = 3;
  localparam int MODE_W = 3;
  localparam int N_SRC  = 1 << SRC_W;
  localparam int CTL_W  = 1 + SRC_W + MODE_W;

  typedef enum logic [MODE_W-1:0] {
    SM_OFF    = 3'b000,
    SM_ENC_A  = 3'b001,
    SM_ENC_B  = 3'b010,
    SM_ENC_C  = 3'b011,
    SM_CLEAR  = 3'b100,
    SM_GATE   = 3'b101,
    SM_START  = 3'b110,
    SM_EXTCLK = 3'b111
  } slave_mode_e;

  typedef struct packed {
    logic             sync;
    logic [SRC_W-1:0] src;
    slave_mode_e      mode;
  } slave_ctl_t;

endpackage

// File: rtl/tmr_slave_regs.sv
module tmr_slave_regs
  import tmr_slave_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_din,
  input  logic             en_wr,
  input  logic             en_val,
  input  logic             start,
  output slave_ctl_t       ctl,
  output logic             cnt_en
);

  slave_ctl_t ctl_q, ctl_d;
  logic       en_q, en_d, en_ld;

  always_comb begin
    ctl_d = slave_ctl_t'(ctl_din);
  end

  // Trigger start dominates a software write in the same cycle.
  always_comb begin
    en_ld = start | en_wr;
    en_d  = start ? 1'b1 : en_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_wr) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_ld) begin
      en_q <= en_d;
    end
  end

  assign ctl    = ctl_q;
  assign cnt_en = en_q;

  // R7: a start request always leaves the enable set
  a_r7_start_sets_en: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> en_q);

endmodule

// File: rtl/tmr_slave_trigsel.sv
module tmr_slave_trigsel
  import tmr_slave_pkg::*;
#(
  parameter int NSRC = N_SRC
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         trig_in,
  input  logic [$clog2(NSRC)-1:0] src,
  output logic                    sel,
  output logic                    rise
);

  localparam int SW = $clog2(NSRC);

  logic [NSRC-1:0] hit;
  logic            sel_q;

  generate
    for (genvar k = 0; k < NSRC; k++) begin : g_dec
      assign hit[k] = trig_in[k] & (src == SW'(k));
    end
  endgenerate

  always_comb begin
    sel  = |hit;
    rise = sel & ~sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else begin
      sel_q <= sel;
    end
  end

  // R2: the selected line is one of the candidates, never more than one
  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: rtl/tmr_slave_mode.sv
module tmr_slave_mode
  import tmr_slave_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  slave_mode_e mode,
  input  logic        sel,
  input  logic        rise,
  input  logic        cnt_en,
  output logic        tick,
  output logic        clear,
  output logic        start,
  output logic        trig_evt
);

  logic slave_act;

  always_comb begin
    slave_act = 1'b0;
    tick      = 1'b0;
    clear     = 1'b0;
    start     = 1'b0;
    unique case (mode)
      SM_OFF, SM_ENC_A, SM_ENC_B, SM_ENC_C: begin
        tick = cnt_en;
      end
      SM_CLEAR: begin
        slave_act = 1'b1;
        tick      = cnt_en;
        clear     = rise;
      end
      SM_GATE: begin
        slave_act = 1'b1;
        tick      = cnt_en & sel;
      end
      SM_START: begin
        slave_act = 1'b1;
        tick      = cnt_en;
        start     = rise;
      end
      SM_EXTCLK: begin
        slave_act = 1'b1;
        tick      = cnt_en & rise;
      end
      default: begin
        tick = cnt_en;
      end
    endcase
    trig_evt = slave_act & rise;
  end

  // R8: in external clock mode a count needs a trigger edge
  a_r8_ext_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SM_EXTCLK && tick) |-> rise);

  // R6: gated mode never counts with the line low
  a_r6_gate_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SM_GATE && tick) |-> sel);

  // R12: no trigger event with slave control off or in encoder modes
  a_r12_evt_mode: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt |-> mode[2]);

endmodule

// File: rtl/tmr_slave_counter.sv
module tmr_slave_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clear,
  input  logic [CW-1:0] arr,
  output logic [CW-1:0] count,
  output logic          ovf
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          cnt_ld;

  always_comb begin
    cnt_d  = cnt_q;
    ovf_d  = 1'b0;
    cnt_ld = clear | tick;
    if (clear) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == arr) begin
        cnt_d = '0;
        ovf_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ld) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
    end
  end

  assign count = cnt_q;
  assign ovf   = ovf_q;

  // R10: a clear wins over counting and suppresses the wrap pulse
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0 && !ovf_q));

  // R3: without a tick or clear the count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !tick) |=> $stable(cnt_q));

  // R9: the wrap pulse coincides with a zero count
  a_r9_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == '0));

endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl
  import tmr_slave_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_din,
  input  logic             cnt_en_wr,
  input  logic             cnt_en_val,
  input  logic [CNT_W-1:0] arr,
  input  logic [N_SRC-1:0] trig_in,
  output logic [CNT_W-1:0] count,
  output logic             cnt_en,
  output logic             trig_evt,
  output logic             ovf,
  output logic             sync_en
);

  logic       rst_s1, rst_s2;
  slave_ctl_t ctl;
  logic       sel, rise, tick, clear, start;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  tmr_slave_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_s2),
    .ctl_wr  (ctl_wr),
    .ctl_din (ctl_din),
    .en_wr   (cnt_en_wr),
    .en_val  (cnt_en_val),
    .start   (start),
    .ctl     (ctl),
    .cnt_en  (cnt_en)
  );

  tmr_slave_trigsel #(.NSRC(N_SRC)) u_trigsel (
    .clk     (clk),
    .rst_n   (rst_s2),
    .trig_in (trig_in),
    .src     (ctl.src),
    .sel     (sel),
    .rise    (rise)
  );

  tmr_slave_mode u_mode (
    .clk      (clk),
    .rst_n    (rst_s2),
    .mode     (ctl.mode),
    .sel      (sel),
    .rise     (rise),
    .cnt_en   (cnt_en),
    .tick     (tick),
    .clear    (clear),
    .start    (start),
    .trig_evt (trig_evt)
  );

  tmr_slave_counter #(.CW(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_s2),
    .tick  (tick),
    .clear (clear),
    .arr   (arr),
    .count (count),
    .ovf   (ovf)
  );

  assign sync_en = ctl.sync;

  // R5: a reset-mode edge always flags a trigger event
  a_r5_clear_flags: assert property (@(posedge clk) disable iff (!rst_s2)
    (ctl.mode == SM_CLEAR && rise) |-> trig_evt);

endmodule

// File: tb/tb_tmr_slave_ctrl.sv
module tb_tmr_slave_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_wr = 1'b0;
  logic [6:0]    ctl_din = '0;
  logic          cnt_en_wr = 1'b0;
  logic          cnt_en_val = 1'b0;
  logic [CW-1:0] arr = 16'd9;
  logic [7:0]    trig_in = '0;
  logic [CW-1:0] count;
  logic          cnt_en, trig_evt, ovf, sync_en;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [CW-1:0] cnt;
    logic          en;
    logic          ovf;
    logic          sync;
    int            req;
  } exp_t;

  exp_t q[$];

  // reference state
  logic [CW-1:0] m_cnt = '0;
  logic          m_en = 1'b0, m_prev = 1'b0, m_sync = 1'b0;
  logic [2:0]    m_mode = '0, m_src = '0;
  logic [15:0]   lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_slave_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_din(ctl_din),
    .cnt_en_wr(cnt_en_wr), .cnt_en_val(cnt_en_val), .arr(arr),
    .trig_in(trig_in), .count(count), .cnt_en(cnt_en),
    .trig_evt(trig_evt), .ovf(ovf), .sync_en(sync_en)
  );

  function automatic int mode_req(input logic [2:0] m);
    case (m)
      3'd0: return 3;            // R3
      3'd1, 3'd2, 3'd3: return 4; // R4
      3'd4: return 5;            // R5
      3'd5: return 6;            // R6
      3'd6: return 7;            // R7
      default: return 8;         // R8
    endcase
  endfunction

  // driver: applies one cycle of stimulus, predicts, pushes expectation
  task automatic step(input logic [7:0] trig, input logic ewr, input logic eval,
                      input logic cwr, input logic [6:0] cdin, input int req);
    logic          s, r, clr, tk, ov_n, evt_x;
    logic [CW-1:0] c_n;
    exp_t          e;
    trig_in = trig; cnt_en_wr = ewr; cnt_en_val = eval;
    ctl_wr = cwr; ctl_din = cdin;
    #1;
    s     = trig[m_src];
    r     = s & ~m_prev;
    clr   = (m_mode == 3'd4) && r;
    tk    = m_en && ((m_mode == 3'd5) ? s : (m_mode == 3'd7) ? r : 1'b1);
    evt_x = m_mode[2] && r;
    ov_n  = 1'b0;
    c_n   = m_cnt;
    if (clr) c_n = '0;
    else if (tk) begin
      if (m_cnt == arr) begin c_n = '0; ov_n = 1'b1; end
      else c_n = m_cnt + 1'b1;
    end
    checks++;
    if (trig_evt !== evt_x) begin
      errors++;
      $display("FAIL R12/R%0d trig_evt actual=%0b expected=%0b", req, trig_evt, evt_x);
    end
    if ((m_mode == 3'd6) && r) m_en = 1'b1;
    else if (ewr) m_en = eval;
    m_cnt = c_n; m_prev = s;
    if (cwr) begin m_mode = cdin[2:0]; m_src = cdin[5:3]; m_sync = cdin[6]; end
    e.cnt = m_cnt; e.en = m_en; e.ovf = ov_n; e.sync = m_sync; e.req = req;
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (count !== e.cnt || cnt_en !== e.en || ovf !== e.ovf || sync_en !== e.sync) begin
          errors++;
          $display("FAIL R%0d cnt/en/ovf/sync actual=%0d/%0b/%0b/%0b expected=%0d/%0b/%0b/%0b",
                   e.req, count, cnt_en, ovf, sync_en, e.cnt, e.en, e.ovf, e.sync);
        end
      end
    end
  end

  task automatic idle(input int n, input int req);
    for (int i = 0; i < n; i++) step(trig_in, 1'b0, 1'b0, 1'b0, ctl_din, req);
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (count !== 0 || cnt_en !== 0 || ovf !== 0 || sync_en !== 0 || trig_evt !== 0) begin
      errors++;
      $display("FAIL R1 reset actual=%0d/%0b/%0b/%0b expected=0/0/0/0", count, cnt_en, ovf, sync_en);
    end
    // R11: sync bit written and visible, mode 000 source 0
    step(8'h00, 1'b0, 1'b0, 1'b1, 7'b1_000_000, 11);
    // R12: rising edge with slave control off gives no event
    step(8'h01, 1'b0, 1'b0, 1'b0, 7'b1_000_000, 12);
    // R3: enable and free-run; R9: wrap at arr=9 twice
    step(8'h00, 1'b1, 1'b1, 1'b0, 7'b1_000_000, 3);
    idle(22, 9);
    // R10: reset mode, source 2, edge arrives with count == arr
    arr = 16'd4;
    step(8'h00, 1'b0, 1'b0, 1'b1, 7'b0_010_100, 10);
    while (m_cnt != arr) step(8'h00, 1'b0, 1'b0, 1'b0, 7'b0_010_100, 10);
    step(8'h04, 1'b0, 1'b0, 1'b0, 7'b0_010_100, 10);
    idle(3, 10);
    // R7: trigger mode, edge coinciding with software clear
    step(8'h00, 1'b1, 1'b0, 1'b1, 7'b0_100_110, 7);
    idle(3, 7);
    step(8'h10, 1'b1, 1'b0, 1'b0, 7'b0_100_110, 7);
    idle(4, 7);
    // R2 with every mode: sweep all modes and sources, pseudo-random lines
    for (int md = 0; md < 8; md++) begin
      for (int sr = 0; sr < 8; sr++) begin
        arr = 16'(3 + md);
        step(lfsr[7:0], 1'b1, 1'b1, 1'b1, {sr[0], sr[2:0], md[2:0]}, 2);
        for (int c = 0; c < 14; c++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          step(lfsr[7:0], lfsr[12:10] == 3'd0, lfsr[9], 1'b0, ctl_din,
               mode_req(3'(md)));
        end
      end
    end
    @(posedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule